// File: doc/BRIEF.md
# DMA Channel Request Gating Arbiter

This block sits in front of a DMA transfer engine. It collects transfer requests for up to 32 channels and filters each one through that channel's control state. It then hands exactly one channel at a time to the engine. For each channel, a 4-bit source-select field picks one of several peripheral request lines. Every peripheral line comes in two forms, a single request and a burst request. Software can also post a one-shot request for any channel.

Software controls each channel through pairs of write-one-to-set and write-one-to-clear registers. The per-channel bits are enable, request mask, high priority, burst-only and alternate structure. A master enable bit in the configuration register gates all new grants. When a grant is issued, the block presents the channel number and whether the grant is for a burst or a single transfer. The grant then stays frozen until the engine returns a done pulse. If that done pulse is marked as the end of the transfer, the channel's enable bit clears by itself.

Top module: `dma_req_arb`

## Requirements
- R1: After reset, all per-channel bits, all source fields, the master enable, the software requests and the read data are 0, and no grant is presented.
- R2: Writing 1s to a set register (enable word 2, mask 4, priority 6, burst-only 8, alternate 10) sets only those channels' bits. Writing 1s to the matching clear register (3, 5, 7, 9, 11) clears only those bits. A 0 bit has no effect. Reading either address of a pair returns the current vector, channel n at bit n.
- R3: The source field of channel n is held in map word 16 + n/8, at bits [4*(n%8)+3 : 4*(n%8)]. Values 0 to 4 select peripheral line n*5+value of `pend_single` and `pend_burst`. Values 5 to 15 select no request.
- R4: While a channel's mask bit is set, its peripheral lines are ignored. A software request for that channel is still granted.
- R5: Writing 1s to word 12 posts one pending software request per channel. The request is removed when that channel is granted, so one write yields exactly one grant. Word 12 reads back the pending vector.
- R6: A burst-only channel ignores its single line and is granted only on its burst line. `gnt_burst` is 1 when the grant was caused by a burst line or a software request, and 0 for a grant caused only by a single line.
- R7: Word 13 bit n reads 1 when channel n is burst-only and unmasked, and has its selected single line high while its burst line is low.
- R8: Bit 0 of word 0 is the master enable. While it is 0, no new grant is issued. Word 1 reports the master enable in bit 0 and an outstanding grant in bit 8.
- R9: Among the eligible channels (enabled and with an unblocked request), high-priority channels win over the others. Within the same level, the lowest channel number wins.
- R10: A grant appears one cycle after the cycle in which it was decided, and stays unchanged until `eng_done`. It drops one cycle after `eng_done`. `eng_done` has no effect while no grant is outstanding.
- R11: An `eng_done` pulse that comes with `eng_end` clears the granted channel's enable bit. Without `eng_end`, the enable bit stays set.
- R12: `reg_rdata` shows the register at `reg_addr` one cycle after the address is applied. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pend_single | input | 160 | Single request lines, channel n source s at bit n*5+s |
| pend_burst | input | 160 | Burst request lines, same layout |
| eng_done | input | 1 | Engine finished the current grant |
| eng_end | input | 1 | With eng_done: the channel's whole transfer is complete |
| gnt_valid | output | 1 | A grant is outstanding |
| gnt_ch | output | 5 | Granted channel |
| gnt_burst | output | 1 | 1 burst grant, 0 single grant |

## Verification
The hardest situation to reach is contention: several channels eligible in the same cycle, with mixed priority levels and a mix of software, masked and burst-only causes. The stimulus builds it with master enable off. It enables the channels, posts the requests and sets one high-priority channel, then turns master enable on and serves the grants one by one, so the order shows up at the ports. A second case raises a lower-numbered request while a grant is held, to prove the grant does not move before the done pulse.

// File: rtl/dra_pkg.sv
package dra_pkg;
  localparam int DATA_W   = 32;
  localparam int MAP_BASE = 16;
  // word addresses of the control registers
  localparam int W_CFG  = 0;
  localparam int W_STAT = 1;
  localparam int W_ENS  = 2;
  localparam int W_ENC  = 3;
  localparam int W_MKS  = 4;
  localparam int W_MKC  = 5;
  localparam int W_PRS  = 6;
  localparam int W_PRC  = 7;
  localparam int W_BOS  = 8;
  localparam int W_BOC  = 9;
  localparam int W_ALS  = 10;
  localparam int W_ALC  = 11;
  localparam int W_SWR  = 12;
  localparam int W_WAIT = 13;
endpackage

// File: rtl/dra_src_sel.sv
module dra_src_sel #(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_CH*SEL_W-1:0]   sel,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_single,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_burst,
  output logic [NUM_CH-1:0]         s_req,
  output logic [NUM_CH-1:0]         b_req
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_comb begin
      s_req[n] = 1'b0;
      b_req[n] = 1'b0;
      for (int j = 0; j < NUM_SRC; j++) begin
        if (sel[n*SEL_W +: SEL_W] == SEL_W'(j)) begin
          s_req[n] = pend_single[n*NUM_SRC + j];
          b_req[n] = pend_burst[n*NUM_SRC + j];
        end
      end
    end
  end
endmodule

// File: rtl/dra_pick.sv
module dra_pick #(
  parameter int NUM_CH = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic [NUM_CH-1:0] prio,
  output logic              hit,
  output logic [CH_W-1:0]   idx
);
  logic [NUM_CH-1:0] hi, cand;
  always_comb begin
    hi   = elig & prio;
    cand = (|hi) ? hi : elig;
    hit  = |elig;
    idx  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/dra_regs.sv
module dra_regs
  import dra_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 5,
  localparam int PER_MAP  = DATA_W / SEL_W,
  localparam int MAP_REGS = (NUM_CH + PER_MAP - 1) / PER_MAP,
  localparam int MI_W     = (MAP_REGS > 1) ? $clog2(MAP_REGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_CH-1:0]       clr_en,
  input  logic [NUM_CH-1:0]       clr_sw,
  input  logic [NUM_CH-1:0]       wait_vec,
  input  logic                    busy,
  output logic                    master,
  output logic [NUM_CH-1:0]       en_q,
  output logic [NUM_CH-1:0]       mask_q,
  output logic [NUM_CH-1:0]       prio_q,
  output logic [NUM_CH-1:0]       bonly_q,
  output logic [NUM_CH-1:0]       sw_q,
  output logic [NUM_CH*SEL_W-1:0] sel,
  output logic [DATA_W-1:0]       rdata
);
  logic [NUM_CH-1:0] alt_q, wv;
  logic [DATA_W-1:0] map_q [MAP_REGS];
  logic [DATA_W-1:0] rd_c;
  logic [ADDR_W-1:0] moff;

  assign wv   = wdata[NUM_CH-1:0];
  assign moff = addr - ADDR_W'(MAP_BASE);

  function automatic logic [NUM_CH-1:0] upd(input logic [NUM_CH-1:0] cur,
                                            input logic s, input logic c,
                                            input logic [NUM_CH-1:0] v);
    if (s)      return cur | v;
    else if (c) return cur & ~v;
    else        return cur;
  endfunction

  function automatic logic hitw(input logic w, input logic [ADDR_W-1:0] a, input int k);
    return w && (a == ADDR_W'(k));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      master  <= 1'b0;
      en_q    <= '0;
      mask_q  <= '0;
      prio_q  <= '0;
      bonly_q <= '0;
      alt_q   <= '0;
      sw_q    <= '0;
    end else begin
      if (hitw(wr, addr, W_CFG)) master <= wdata[0];
      en_q    <= upd(en_q & ~clr_en, hitw(wr, addr, W_ENS), hitw(wr, addr, W_ENC), wv);
      mask_q  <= upd(mask_q,  hitw(wr, addr, W_MKS), hitw(wr, addr, W_MKC), wv);
      prio_q  <= upd(prio_q,  hitw(wr, addr, W_PRS), hitw(wr, addr, W_PRC), wv);
      bonly_q <= upd(bonly_q, hitw(wr, addr, W_BOS), hitw(wr, addr, W_BOC), wv);
      alt_q   <= upd(alt_q,   hitw(wr, addr, W_ALS), hitw(wr, addr, W_ALC), wv);
      sw_q    <= upd(sw_q & ~clr_sw, hitw(wr, addr, W_SWR), 1'b0, wv);
    end
  end

  for (genvar k = 0; k < MAP_REGS; k++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst) map_q[k] <= '0;
      else if (hitw(wr, addr, MAP_BASE + k)) map_q[k] <= wdata;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
    assign sel[n*SEL_W +: SEL_W] = map_q[n / PER_MAP][(n % PER_MAP)*SEL_W +: SEL_W];
  end

  always_comb begin
    rd_c = '0;
    case (addr)
      ADDR_W'(W_CFG):  rd_c[0] = master;
      ADDR_W'(W_STAT): begin rd_c[0] = master; rd_c[8] = busy; end
      ADDR_W'(W_ENS), ADDR_W'(W_ENC): rd_c[NUM_CH-1:0] = en_q;
      ADDR_W'(W_MKS), ADDR_W'(W_MKC): rd_c[NUM_CH-1:0] = mask_q;
      ADDR_W'(W_PRS), ADDR_W'(W_PRC): rd_c[NUM_CH-1:0] = prio_q;
      ADDR_W'(W_BOS), ADDR_W'(W_BOC): rd_c[NUM_CH-1:0] = bonly_q;
      ADDR_W'(W_ALS), ADDR_W'(W_ALC): rd_c[NUM_CH-1:0] = alt_q;
      ADDR_W'(W_SWR):  rd_c[NUM_CH-1:0] = sw_q;
      ADDR_W'(W_WAIT): rd_c[NUM_CH-1:0] = wait_vec;
      default: if (moff < ADDR_W'(MAP_REGS)) rd_c = map_q[moff[MI_W-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_c;
  end

  // R5: a granted software request is gone on the next cycle unless rewritten
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_sw_taken_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_sw[n] && !wr) |=> !sw_q[n]);
  end
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dra_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 4,
  parameter int ADDR_W  = 5,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_single,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_burst,
  input  logic                      eng_done,
  input  logic                      eng_end,
  output logic                      gnt_valid,
  output logic [CH_W-1:0]           gnt_ch,
  output logic                      gnt_burst
);
  logic                    master, issue, hit;
  logic [NUM_CH-1:0]       en_q, mask_q, prio_q, bonly_q, sw_q;
  logic [NUM_CH-1:0]       s_req, b_req, elig, wait_vec, clr_en, clr_sw;
  logic [NUM_CH*SEL_W-1:0] sel;
  logic [CH_W-1:0]         pidx;

  dra_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .clr_en(clr_en), .clr_sw(clr_sw), .wait_vec(wait_vec), .busy(gnt_valid),
    .master(master), .en_q(en_q), .mask_q(mask_q), .prio_q(prio_q),
    .bonly_q(bonly_q), .sw_q(sw_q), .sel(sel), .rdata(reg_rdata));

  dra_src_sel #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .sel(sel), .pend_single(pend_single), .pend_burst(pend_burst),
    .s_req(s_req), .b_req(b_req));

  // hardware causes pass only when unmasked; singles only when not burst-only
  assign elig     = en_q & (sw_q | (~mask_q & (b_req | (s_req & ~bonly_q))));
  assign wait_vec = bonly_q & ~mask_q & s_req & ~b_req;

  dra_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig(elig), .prio(prio_q), .hit(hit), .idx(pidx));

  assign issue  = !gnt_valid && master && hit;
  assign clr_sw = issue ? (NUM_CH'(1) << pidx) : '0;
  assign clr_en = (gnt_valid && eng_done && eng_end) ? (NUM_CH'(1) << gnt_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_ch    <= '0;
      gnt_burst <= 1'b0;
    end else if (gnt_valid) begin
      if (eng_done) gnt_valid <= 1'b0;
    end else if (issue) begin
      gnt_valid <= 1'b1;
      gnt_ch    <= pidx;
      gnt_burst <= sw_q[pidx] | b_req[pidx];
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !eng_done) |=> (gnt_valid && $stable(gnt_ch) && $stable(gnt_burst)));
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && eng_done) |=> !gnt_valid);
  assert_master_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !master |=> !$rose(gnt_valid));
  assert_high_first_R9: assert property (@(posedge clk) disable iff (rst)
    (issue && |(elig & prio_q)) |-> prio_q[pidx]);
  assert_lowest_R9: assert property (@(posedge clk) disable iff (rst)
    issue |-> (elig[pidx] &&
      (((elig & (prio_q[pidx] ? prio_q : ~prio_q)) & ~({NUM_CH{1'b1}} << pidx)) == '0)));
  assert_mask_sw_R4: assert property (@(posedge clk) disable iff (rst)
    (issue && mask_q[pidx]) |-> sw_q[pidx]);
  assert_burst_only_R6: assert property (@(posedge clk) disable iff (rst)
    (issue && bonly_q[pidx] && !sw_q[pidx]) |-> b_req[pidx]);
  assert_end_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && eng_done && eng_end && !reg_wr) |=> !en_q[$past(gnt_ch)]);
endmodule

// File: tb/dma_req_arb_tb_top.sv
`timescale 1ns/1ps
module dma_req_arb_tb_top;
  localparam int NCH = 32;
  localparam int NS  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH*NS-1:0] ps = '0, pb = '0;
  logic eng_done = 1'b0, eng_end = 1'b0;
  logic gnt_valid, gnt_burst;
  logic [4:0] gnt_ch;

  always #2 clk = ~clk;

  dma_req_arb dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_single(ps),
    .pend_burst(pb), .eng_done(eng_done), .eng_end(eng_end),
    .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .gnt_burst(gnt_burst));

  int n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference state
  bit [31:0] m_en, m_mk, m_pr, m_bo, m_al, m_sw, m_rd;
  bit [3:0]  m_sel [NCH];
  bit        m_master, m_gv, m_gb;
  int        m_gch;

  function automatic bit sreq(int n);
    return (m_sel[n] < 5) ? ps[n*NS + m_sel[n]] : 1'b0;
  endfunction
  function automatic bit breq(int n);
    return (m_sel[n] < 5) ? pb[n*NS + m_sel[n]] : 1'b0;
  endfunction
  function automatic bit can_go(int n);
    return m_en[n] && (m_sw[n] || (!m_mk[n] && (breq(n) || (sreq(n) && !m_bo[n]))));
  endfunction
  function automatic bit [31:0] waitv();
    bit [31:0] w = 0;
    for (int n = 0; n < NCH; n++) w[n] = m_bo[n] && !m_mk[n] && sreq(n) && !breq(n);
    return w;
  endfunction
  function automatic bit [31:0] model_read(int a);
    bit [31:0] r = 0;
    case (a)
      0: r[0] = m_master;
      1: begin r[0] = m_master; r[8] = m_gv; end
      2, 3: r = m_en;
      4, 5: r = m_mk;
      6, 7: r = m_pr;
      8, 9: r = m_bo;
      10, 11: r = m_al;
      12: r = m_sw;
      13: r = waitv();
      16, 17, 18, 19: for (int i = 0; i < 8; i++) r[i*4 +: 4] = m_sel[(a-16)*8 + i];
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mk = 0; m_pr = 0; m_bo = 0; m_al = 0; m_sw = 0; m_rd = 0;
      m_master = 0; m_gv = 0; m_gb = 0; m_gch = 0;
      for (int n = 0; n < NCH; n++) m_sel[n] = 0;
    end else begin
      bit [31:0] nrd;
      int pick;
      nrd = model_read(int'(reg_addr));
      if (m_gv) begin
        if (eng_done) begin
          m_gv = 0;
          if (eng_end) m_en[m_gch] = 0;
        end
      end else if (m_master) begin
        pick = -1;
        for (int n = 0; n < NCH; n++) if (pick < 0 && can_go(n) && m_pr[n]) pick = n;
        for (int n = 0; n < NCH; n++) if (pick < 0 && can_go(n)) pick = n;
        if (pick >= 0) begin
          m_gv = 1; m_gch = pick; m_gb = m_sw[pick] || breq(pick); m_sw[pick] = 0;
        end
      end
      if (reg_wr) begin
        case (int'(reg_addr))
          0: m_master = reg_wdata[0];
          2: m_en |= reg_wdata;   3: m_en &= ~reg_wdata;
          4: m_mk |= reg_wdata;   5: m_mk &= ~reg_wdata;
          6: m_pr |= reg_wdata;   7: m_pr &= ~reg_wdata;
          8: m_bo |= reg_wdata;   9: m_bo &= ~reg_wdata;
          10: m_al |= reg_wdata;  11: m_al &= ~reg_wdata;
          12: m_sw |= reg_wdata;
          16, 17, 18, 19:
            for (int i = 0; i < 8; i++) m_sel[(int'(reg_addr)-16)*8 + i] = reg_wdata[i*4 +: 4];
          default: ;
        endcase
      end
      m_rd = nrd;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (gnt_valid !== m_gv || reg_rdata !== m_rd ||
          (m_gv && (int'(gnt_ch) != m_gch || gnt_burst !== m_gb))) begin
        n_bad++;
        $display("FAIL %s: valid/ch/burst/rdata act %0d/%0d/%0d/%h exp %0d/%0d/%0d/%h",
                 phase, gnt_valid, gnt_ch, gnt_burst, reg_rdata, m_gv, m_gch, m_gb, m_rd);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rdchk(input int a, input bit [31:0] exp, input string tag);
    reg_addr = 5'(a);
    @(negedge clk);
    chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk(!gnt_valid, tag, int'(gnt_valid), 0);
    end
  endtask

  task automatic serve(input bit last, input int ch, input bit bst, input string tag);
    int t = 0;
    while (!gnt_valid && t < 100) begin @(negedge clk); t++; end
    chk(gnt_valid && int'(gnt_ch) == ch, tag, int'(gnt_ch), ch);
    chk(gnt_burst == bst, tag, int'(gnt_burst), int'(bst));
    eng_done = 1; eng_end = last;
    @(negedge clk);
    eng_done = 0; eng_end = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R10 watchdog: cycles %0d expected below %0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R1";
    rdchk(2, 0, "R1 enable after reset");
    rdchk(16, 0, "R1 map after reset");
    idle(2, "R1 no grant after reset");

    phase = "R2";
    wr(2, 32'h0000_0005);
    wr(3, 32'h0000_0001);
    wr(2, 32'h0);
    rdchk(3, 32'h4, "R2 enable set/clear");
    wr(4, 32'hF0); wr(5, 32'h30); rdchk(4, 32'hC0, "R2 mask set/clear");
    wr(8, 32'h8000_0001); wr(9, 32'h1); rdchk(9, 32'h8000_0000, "R2 burst-only");
    wr(10, 32'h3); wr(11, 32'h0); rdchk(11, 32'h3, "R12 alternate read");
    rdchk(14, 0, "R12 unused address");
    wr(3, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); wr(9, 32'hFFFF_FFFF); wr(11, 32'h3);

    phase = "R3";
    wr(0, 1);
    wr(16, 32'h0000_0032);
    wr(17, 32'h0000_0070);
    rdchk(17, 32'h70, "R3 map readback");
    wr(2, 32'h0000_0201);
    ps[0*NS + 1] = 1;
    idle(4, "R3 unselected line");
    ps = '0; ps[0*NS + 2] = 1;
    serve(1, 0, 0, "R3 selected single line");
    ps = '0;
    rdchk(2, 32'h200, "R11 enable cleared on end");
    for (int s = 0; s < NS; s++) begin ps[9*NS + s] = 1; pb[9*NS + s] = 1; end
    idle(5, "R3 illegal select");
    ps = '0; pb = '0;
    wr(3, 32'hFFFF_FFFF);

    phase = "R4";
    wr(4, 32'h20); wr(2, 32'h20);
    ps[5*NS] = 1; pb[5*NS] = 1;
    idle(4, "R4 masked hardware");
    wr(12, 32'h20);
    serve(1, 5, 1, "R4 software through mask");
    ps = '0; pb = '0; wr(5, 32'h20);

    phase = "R5";
    wr(2, 32'h80);
    wr(12, 32'h80);
    rdchk(12, 32'h80, "R5 pending readback");
    serve(0, 7, 1, "R5 software grant");
    rdchk(2, 32'h80, "R11 enable kept without end");
    idle(4, "R5 one shot");
    eng_done = 1; @(negedge clk); eng_done = 0;
    rdchk(2, 32'h80, "R10 done while idle");
    wr(12, 32'h80);
    serve(1, 7, 1, "R5 second request");

    phase = "R6";
    wr(8, 32'h8); wr(2, 32'h8);
    ps[3*NS] = 1;
    idle(3, "R6 single ignored");
    rdchk(13, 32'h8, "R7 wait status");
    pb[3*NS] = 1;
    rdchk(13, 32'h0, "R7 wait cleared by burst");
    serve(1, 3, 1, "R6 burst grant");
    ps = '0; pb = '0; wr(9, 32'h8);

    phase = "R8";
    wr(0, 0);
    wr(2, 32'h4); wr(12, 32'h4);
    idle(5, "R8 master off");
    rdchk(1, 32'h0, "R8 status off");
    wr(0, 1);
    @(negedge clk);
    rdchk(1, 32'h101, "R8 status busy");
    serve(1, 2, 1, "R8 grant after master on");

    phase = "R9";
    wr(0, 0);
    wr(6, 32'h0010_0000);
    wr(2, 32'h0010_0410);
    wr(12, 32'h0010_0400);
    ps[4*NS] = 1;
    wr(0, 1);
    serve(1, 20, 1, "R9 high priority first");
    serve(1, 4, 0, "R9 lowest index next");
    ps = '0;
    serve(1, 10, 1, "R9 remaining channel");
    wr(7, 32'h0010_0000);

    phase = "R10";
    wr(2, 32'h40); wr(12, 32'h40);
    @(negedge clk); @(negedge clk);
    wr(2, 32'h1); wr(12, 32'h1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(gnt_valid && gnt_ch == 5'd6, "R10 grant held", int'(gnt_ch), 6);
    end
    serve(1, 6, 1, "R10 held grant");
    serve(1, 0, 1, "R10 next grant");
    idle(3, "R10 all served");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule